// File: doc/BRIEF.md
# Byte-Wide SPI Master/Slave Port

This block is a synchronous serial port that moves one byte at a time, MSB first, either as the SPI clock master or as a slave that follows an external SCK. A CPU-side control register holds the port enable, the clock polarity, a 4-bit operating mode and two sticky error flags. A single data buffer register is used in both directions. Writing it loads the internal shift register and, in master mode, starts a transfer. Reading it returns the last byte received.

In master mode the serial clock is derived from the system clock by one of three fixed dividers, or from an external timer tick. In slave mode SCK and the active-low select are synchronised before edge detection. The select can be honoured or ignored. Each completed byte gives a one-cycle pulse. A write to the buffer during a transfer is refused and raises a collision flag. In slave mode, a byte that completes while the buffer is still unread is thrown away and raises an overflow flag.

Top module: `spi_port`

## Requirements
- R1: The control register reads as {collision[7], overflow[6], enable[5], polarity[4], mode[3:0]} and resets to 0x00. A CPU write loads bits 5:0. A CPU write can clear bit 7 or bit 6 by writing 0 there, and writing 1 to either bit never sets it.
- R2: In master mode, codes 0000, 0001 and 0010 give an SCK period of 4, 16 and 64 system clocks.
- R3: In master mode, code 0011 toggles SCK once per timer tick while a transfer runs, so the SCK period is two ticks.
- R4: SCK idles at the polarity bit. The leading edge (away from idle) launches the next SDO bit, and the trailing edge samples SDI. Bits go MSB first.
- R5: In master mode, a buffer write while idle starts an 8-bit transfer. At its end, the received byte is placed in the buffer, buf_full is set and xfer_done pulses for exactly one cycle.
- R6: A buffer write during a transfer is ignored, sets the collision flag, and does not disturb the byte being sent. The flag stays set until the CPU clears it.
- R7: The overflow flag never sets in master mode. A new master byte overwrites an unread buffer.
- R8: In slave mode 0101, the port shifts on the external SCK whatever the select level. It returns the loaded byte on SDO, stores the received byte and pulses xfer_done.
- R9: In slave mode, a byte that completes while buf_full is set sets the overflow flag and is discarded, and the buffer keeps the old byte. xfer_done still pulses.
- R10: In slave mode 0100, a high select releases SDO (sdo_oe low) and discards a partly shifted byte, so the next full byte is received correctly.
- R11: A pulse on buf_rd clears buf_full.
- R12: With the enable bit clear, SCK sits at the polarity level and SDO is 0. A transfer running when the port is disabled is abandoned without a completion pulse.
- R13: Mode codes other than 0000–0101 leave the port idle: buffer writes start nothing, SCK stays still, SDO is not driven and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Control register contents |
| buf_wr | input | 1 | Data buffer write strobe |
| buf_wdata | input | 8 | Byte to transmit |
| buf_rd | input | 1 | Data buffer read strobe (clears buf_full) |
| buf_rdata | output | 8 | Last accepted received byte |
| buf_full | output | 1 | Unread received byte present |
| xfer_done | output | 1 | One-cycle pulse per completed byte |
| timer_tick | input | 1 | External rate tick for master code 0011 |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock input in slave mode |
| sel_n_i | input | 1 | Active-low slave select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for SDO |

## Verification
The bench measures SCK periods for every master rate, including the timer-driven rate, so a divider off by one or a clock toggled on both tick edges shows up as a wrong period. It injects a buffer write partway through a master byte: a design that accepts the write corrupts the transmitted byte, and one that drops the flag leaves collision clear. Slave bytes are sent into a full buffer to check that the old byte survives. A select pulse aborts a partial slave byte, and a design that keeps the stale bit count misaligns the next byte. Disabling the port mid-transfer and using reserved mode codes confirm that SCK and SDO stay quiet and no completion pulse appears.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
    localparam int DW    = 8;
    localparam int CNT_W = $clog2(DW);

    typedef struct packed {
        logic       wcol;
        logic       ovf;
        logic       en;
        logic       ckp;
        logic [3:0] mode;
    } ctl_t;

    typedef struct packed {
        ctl_t             ctl;
        logic [DW-1:0]    shreg;
        logic [DW-1:0]    rbuf;
        logic             full;
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             phase;
        logic             tog;
        logic             sdo;
        logic             done;
        logic             sck_prev;
    } st_t;

    function automatic logic is_master(input logic [3:0] m);
        return m[3:2] == 2'b00;
    endfunction

    function automatic logic is_slave(input logic [3:0] m);
        return m[3:1] == 3'b010;
    endfunction

    function automatic logic sel_used(input logic [3:0] m);
        return m == 4'b0100;
    endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int          W      = 2,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     stg_q[s] <= INIT;
            else if (s == 0) stg_q[s] <= in_i;
            else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
        end
    end

    assign out_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
    parameter int BASE_HALF = 2,
    parameter int STEP      = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [1:0] rate_i,
    input  logic       tick_i,
    output logic       half_o
);
    localparam int MAXH = BASE_HALF << (2 * STEP);
    localparam int CW   = $clog2(MAXH);

    logic [CW-1:0] cnt_d, cnt_q, lim;
    logic          ext;

    always_comb begin
        ext   = (rate_i == 2'b11);
        lim   = CW'((BASE_HALF << (STEP * int'(rate_i))) - 1);
        half_o = run_i && (ext ? tick_i : (cnt_q == lim));
        if (!run_i || ext || cnt_q == lim) cnt_d = '0;
        else                               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int BASE_HALF = 2,
    parameter int RATE_STEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [DW-1:0] ctl_wdata,
    output logic [DW-1:0] ctl_rdata,
    input  logic          buf_wr,
    input  logic [DW-1:0] buf_wdata,
    input  logic          buf_rd,
    output logic [DW-1:0] buf_rdata,
    output logic          buf_full,
    output logic          xfer_done,
    input  logic          timer_tick,
    output logic          sck_o,
    input  logic          sck_i,
    input  logic          sel_n_i,
    input  logic          sdi_i,
    output logic          sdo_o,
    output logic          sdo_oe
);
    st_t  d, q;
    logic sck_s, sel_s, half;
    logic mst, slv, slv_ok, lead_ev, trail_ev, edge_r, edge_f;
    logic [DW-1:0] shifted;

    spi_sync #(.W(2), .STAGES(2), .INIT(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  ({sel_n_i, sck_i}),
        .out_o ({sel_s, sck_s})
    );

    spi_clkgen #(.BASE_HALF(BASE_HALF), .STEP(RATE_STEP)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (q.ctl.en && is_master(q.ctl.mode) && q.busy),
        .rate_i (q.ctl.mode[1:0]),
        .tick_i (timer_tick),
        .half_o (half)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.sck_prev = sck_s;

        mst    = q.ctl.en && is_master(q.ctl.mode);
        slv    = q.ctl.en && is_slave(q.ctl.mode);
        slv_ok = slv && (!sel_used(q.ctl.mode) || !sel_s);
        edge_r = sck_s && !q.sck_prev;
        edge_f = !sck_s && q.sck_prev;

        lead_ev  = (mst && q.busy && half && !q.phase) ||
                   (slv_ok && (q.ctl.ckp ? edge_f : edge_r));
        trail_ev = (mst && q.busy && half && q.phase) ||
                   (slv_ok && (q.ctl.ckp ? edge_r : edge_f));
        shifted  = {q.shreg[DW-2:0], sdi_i};

        // control register write: flags can only be cleared
        if (ctl_wr) begin
            d.ctl      = ctl_t'(ctl_wdata);
            d.ctl.wcol = q.ctl.wcol & ctl_wdata[7];
            d.ctl.ovf  = q.ctl.ovf  & ctl_wdata[6];
        end

        if (buf_rd) d.full = 1'b0;

        if (mst && q.busy && half) begin
            d.tog   = !q.tog;
            d.phase = !q.phase;
        end

        if (lead_ev) begin
            d.sdo = q.shreg[DW-1];
            if (slv) d.busy = 1'b1;
        end

        if (trail_ev) begin
            d.shreg = shifted;
            d.cnt   = q.cnt + 1'b1;
            if (q.cnt == CNT_W'(DW-1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                if (slv && q.full) begin
                    d.ctl.ovf = 1'b1;
                end else begin
                    d.rbuf = shifted;
                    d.full = 1'b1;
                end
            end
        end

        if (buf_wr && (mst || slv)) begin
            if (q.busy) begin
                d.ctl.wcol = 1'b1;
            end else begin
                d.shreg = buf_wdata;
                if (mst) begin
                    d.busy  = 1'b1;
                    d.phase = 1'b0;
                    d.cnt   = '0;
                end
            end
        end

        // deselected slave drops any partial byte
        if (slv && sel_used(q.ctl.mode) && sel_s) begin
            d.cnt  = '0;
            d.busy = 1'b0;
        end

        if (!mst) begin
            d.tog   = 1'b0;
            d.phase = 1'b0;
        end

        if (!q.ctl.en || !(is_master(q.ctl.mode) || is_slave(q.ctl.mode))) begin
            d.busy = 1'b0;
            d.cnt  = '0;
            d.sdo  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctl_rdata = q.ctl;
    assign buf_rdata = q.rbuf;
    assign buf_full  = q.full;
    assign xfer_done = q.done;
    assign sck_o     = q.ctl.ckp ^ q.tog;
    assign sdo_o     = q.sdo;
    assign sdo_oe    = mst || slv_ok;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic [7:0] ctl_rdata,
    input logic       xfer_done,
    input logic       sck_o,
    input logic       sdo_o
);
    logic mode_ok;
    assign mode_ok = (ctl_rdata[3:2] == 2'b00) || (ctl_rdata[3:1] == 3'b010);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);  // R5

    AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[7] && !ctl_wr) |=> ctl_rdata[7]);  // R6

    AST_NO_MASTER_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rdata[6]) |-> $past(ctl_rdata[3:1] == 3'b010));  // R7

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_rdata[5] && $past(!ctl_rdata[5])) |-> (sck_o == ctl_rdata[4] && !sdo_o));  // R12

    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[5] && $past(ctl_rdata[5]) && !mode_ok &&
         $past(ctl_rdata[3:0]) == ctl_rdata[3:0]) |-> !xfer_done);  // R13
endmodule

bind spi_port spi_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_rdata (ctl_rdata),
    .xfer_done (xfer_done),
    .sck_o     (sck_o),
    .sdo_o     (sdo_o)
);

// File: tb/sim_spi_port.sv
module sim_spi_port;
    logic       clk = 0, rst_n = 0;
    logic       ctl_wr = 0, buf_wr = 0, buf_rd = 0, timer_tick = 0;
    logic [7:0] ctl_wdata = 0, buf_wdata = 0;
    logic [7:0] ctl_rdata, buf_rdata;
    logic       buf_full, xfer_done, sck_o, sdo_o, sdo_oe;
    logic       sck_i = 0, sel_n_i = 1, sdi_i = 0;
    int         n_run = 0, n_fail = 0, cyc = 0, done_cnt = 0;
    bit         tick_en = 0, finished = 0;

    spi_port u0 (.*);

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (xfer_done === 1'b1) done_cnt <= done_cnt + 1;

    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph++;
            timer_tick = tick_en && (ph % 3 == 0);
        end
    end

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        report();
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_period(input logic [1:0] rate);
        return (rate == 2'b11) ? 6 : (4 << (2 * rate));
    endfunction

    task automatic cpu_ctl(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 0;
    endtask

    task automatic cpu_buf(input logic [7:0] v);
        @(negedge clk); buf_wr = 1; buf_wdata = v;
        @(negedge clk); buf_wr = 0;
    endtask

    task automatic cpu_rd();
        @(negedge clk); buf_rd = 1;
        @(negedge clk); buf_rd = 0;
    endtask

    task automatic mst_xfer(input logic [3:0] md, input logic ck, input logic [7:0] tx,
                            input logic [7:0] rxp, input bit coll,
                            output logic [7:0] got, output int per, output bit dn);
        logic pv; int bi; int last; bit cd;
        cpu_ctl({3'b001, ck, md});
        cpu_buf(tx);
        pv = sck_o; bi = 0; last = -1; per = 0; dn = 0; got = 0; cd = 0;
        for (int k = 0; k < 4000 && !dn; k++) begin
            @(negedge clk);
            buf_wr = 0;
            if (sck_o !== pv) begin
                if (sck_o != ck) begin
                    if (bi < 8) sdi_i = rxp[7-bi];
                    if (last >= 0) per = cyc - last;
                    last = cyc;
                end else begin
                    if (bi < 8) got[7-bi] = sdo_o;
                    bi++;
                end
                pv = sck_o;
            end
            if (xfer_done) dn = 1;
            if (coll && bi == 3 && !cd) begin
                buf_wr = 1; buf_wdata = ~tx; cd = 1;
            end
        end
        buf_wr = 0;
    endtask

    task automatic slv_setup(input logic [3:0] md, input logic ck);
        cpu_ctl(8'h00);
        sck_i = ck;
        repeat (4) @(negedge clk);
        cpu_ctl({3'b001, ck, md});
        repeat (4) @(negedge clk);
    endtask

    task automatic slv_bits(input logic ck, input logic [7:0] rx, input int nb, output logic [7:0] got);
        got = 0;
        for (int j = 0; j < nb; j++) begin
            sck_i = !ck; sdi_i = rx[7-j];
            repeat (8) @(negedge clk);
            got[7-j] = sdo_o;
            sck_i = ck;
            repeat (8) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [7:0] tx, rx, got, first;
        int per, d0;
        bit dn;
        logic ck;
        logic [1:0] rt;
        void'($urandom(32'h5EED));

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(ctl_rdata == 8'h00, "R1 ctl reset", ctl_rdata, 0);
        chk(sck_o == 0 && sdo_o == 0 && sdo_oe == 0, "R12 pins idle at reset", {sck_o, sdo_o, sdo_oe}, 0);
        chk(buf_full == 0, "R11 buf_full reset", buf_full, 0);

        // R2 R4 R5 random master transfers at the fixed rates
        for (int t = 0; t < 6; t++) begin
            rt = 2'($urandom % 3); ck = 1'($urandom); tx = 8'($urandom); rx = 8'($urandom);
            mst_xfer({2'b00, rt}, ck, tx, rx, 0, got, per, dn);
            chk(per == exp_period(rt), "R2 sck period", per, exp_period(rt));
            chk(got == tx, "R4 msb-first sdo", got, tx);
            chk(dn && buf_rdata == rx, "R5 received byte", buf_rdata, rx);
            chk(buf_full == 1, "R5 buf_full set", buf_full, 1);
            chk(sck_o == ck, "R4 sck idle level", sck_o, ck);
            cpu_rd();
            chk(buf_full == 0, "R11 read clears full", buf_full, 0);
        end

        // R3 timer-driven rate, tick every 3 clocks
        tick_en = 1;
        for (int t = 0; t < 2; t++) begin
            ck = 1'(t); tx = 8'($urandom); rx = 8'($urandom);
            mst_xfer(4'b0011, ck, tx, rx, 0, got, per, dn);
            chk(per == exp_period(2'b11), "R3 timer period", per, 6);
            chk(got == tx && buf_rdata == rx, "R3 timer data", {got, buf_rdata}, {tx, rx});
        end
        tick_en = 0;

        // R6 collision during a transfer
        mst_xfer(4'b0001, 0, 8'hA5, 8'h3C, 1, got, per, dn);
        chk(ctl_rdata[7] == 1, "R6 collision flag", ctl_rdata[7], 1);
        chk(got == 8'hA5, "R6 byte undisturbed", got, 8'hA5);
        cpu_ctl(8'hE1);
        chk(ctl_rdata[7] == 1 && ctl_rdata[5:0] == 6'h21, "R1 write 1 keeps flag", ctl_rdata, 8'hA1);
        cpu_ctl(8'h21);
        chk(ctl_rdata == 8'h21, "R1 write 0 clears flag", ctl_rdata, 8'h21);

        // R7 no overflow in master, overwrite
        mst_xfer(4'b0000, 0, 8'h11, 8'h5A, 0, got, per, dn);
        mst_xfer(4'b0000, 0, 8'h22, 8'hC3, 0, got, per, dn);
        chk(ctl_rdata[6] == 0, "R7 no master overflow", ctl_rdata[6], 0);
        chk(buf_rdata == 8'hC3, "R7 master overwrites", buf_rdata, 8'hC3);
        cpu_rd();

        // R8 slave, select ignored (held high)
        for (int t = 0; t < 4; t++) begin
            ck = 1'($urandom); tx = 8'($urandom); rx = 8'($urandom);
            sel_n_i = 1;
            slv_setup(4'b0101, ck);
            cpu_buf(tx);
            d0 = done_cnt;
            slv_bits(ck, rx, 8, got);
            chk(sdo_oe == 1, "R8 sdo driven", sdo_oe, 1);
            chk(got == tx, "R8 slave sdo", got, tx);
            chk(buf_rdata == rx && done_cnt == d0 + 1, "R8 slave rx", buf_rdata, rx);
            cpu_rd();
        end

        // R9 slave overflow discards
        slv_setup(4'b0101, 0);
        first = 8'($urandom);
        slv_bits(0, first, 8, got);
        d0 = done_cnt;
        slv_bits(0, ~first, 8, got);
        chk(ctl_rdata[6] == 1, "R9 overflow flag", ctl_rdata[6], 1);
        chk(buf_rdata == first, "R9 old byte kept", buf_rdata, first);
        chk(done_cnt == d0 + 1, "R9 pulse on discard", done_cnt - d0, 1);
        cpu_ctl(8'h25);
        chk(ctl_rdata[6] == 0, "R1 clear overflow", ctl_rdata[6], 0);
        cpu_rd();

        // R10 select honoured
        sel_n_i = 1;
        slv_setup(4'b0100, 0);
        chk(sdo_oe == 0, "R10 sdo released", sdo_oe, 0);
        sel_n_i = 0; repeat (4) @(negedge clk);
        slv_bits(0, 8'hFF, 3, got);
        sel_n_i = 1; repeat (6) @(negedge clk);
        sel_n_i = 0; repeat (6) @(negedge clk);
        slv_bits(0, 8'h96, 8, got);
        chk(buf_rdata == 8'h96 && buf_full, "R10 partial discarded", buf_rdata, 8'h96);
        sel_n_i = 1;
        cpu_rd();

        // R12 disable mid-transfer
        cpu_ctl(8'h32);
        cpu_buf(8'hF0);
        repeat (40) @(negedge clk);
        d0 = done_cnt;
        cpu_ctl(8'h12);
        repeat (2) @(negedge clk);
        chk(sck_o == 1 && sdo_o == 0, "R12 idle after disable", {sck_o, sdo_o}, 2'b10);
        repeat (200) @(negedge clk);
        chk(done_cnt == d0, "R12 no completion", done_cnt - d0, 0);

        // R13 reserved mode
        cpu_ctl(8'h26);
        d0 = done_cnt;
        cpu_buf(8'h5A);
        begin
            bit moved = 0;
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                if (sck_o !== 1'b0 || sdo_oe !== 1'b0) moved = 1;
            end
            chk(!moved, "R13 pins quiet", moved, 0);
        end
        chk(done_cnt == d0, "R13 no pulse", done_cnt - d0, 0);

        report();
    end
endmodule